// File: doc/BRIEF.md
# Streaming Write Packet Framer

The framer turns one streaming-write request into a packet on a 128-bit transmit stream. Before the request, the caller fills a 256-byte payload store one 64-bit double-word at a time. It then presents the request fields together with a payload length in bytes: priority, destination and source device IDs (8 bits each), a 29-bit double-word address, the pointer bit and two extended-address bits. The block builds the 8-byte logical header and puts it in the upper half of the first beat. The payload follows directly, so the first payload double-word shares the first beat with the header.

Every beat is presented with valid, start and end markers, the total packet length (header plus payload) and, on the last beat, a count of the unused bytes. A beat moves only when the downstream side raises ready. While ready is low, the beat on the bus stays unchanged. Only 8-bit device IDs and virtual channel 0 are produced. Link-level fields such as the acknowledge ID are driven as zero, for a later stage to fill in.

The controller has three states. `ST_IDLE` waits for a request. `ST_FIRST` presents the header beat. `ST_BODY` presents the remaining beats. The transitions are:
- idle-to-first: a valid length is accepted.
- idle-to-idle with an error pulse: the length is invalid.
- first-to-idle: a one-beat packet is accepted.
- first-to-body: the first beat of a longer packet is accepted.
- body-to-body: a middle beat is accepted.
- body-to-idle: the last beat is accepted.
- any state holds while ready is low.

Top module: `swrite_framer`

## Requirements
- R1: A synchronous active-high reset, including one applied mid-packet, leaves `tx_valid`, `busy` and `req_err` low on the following cycle.
- R2: The upper 64 bits of the first beat are, from MSB down: 6 zero bits, one zero bit, one zero bit, priority (2 bits), `2'b00`, `4'b0110`, destination (8), source (8), address (29), pointer bit (1), extended address (2).
- R3: `tx_size` equals the payload length plus 8 on every beat of the packet.
- R4: A packet with N payload double-words takes floor(N/2)+1 accepted beats. `tx_sop` is high only on the first beat and `tx_eop` only on the last. A 40-byte payload takes exactly 3 beats.
- R5: Payload double-word i (as written at index i) appears at bits [63:0] of beat 0 for i=0. For i≥1 it appears at bits [127:64] of beat (i+1)/2 when i is odd and at bits [63:0] of beat i/2 when i is even. The lowest-addressed byte is in the most significant lane of each double-word.
- R6: `tx_empty` is 8 on the last beat when N is even, and that beat's bits [63:0] are zero. It is 0 when N is odd. On non-final beats it is 0.
- R7: A beat advances only in a cycle with `tx_valid` and `tx_ready` both high. While `tx_ready` is low, data, markers, size and empty hold their values.
- R8: A length that is zero, not a multiple of 8, or above 256 gives a one-cycle `req_err` pulse on the next cycle, and no beat is sent.
- R9: Requests are taken only in idle. `busy` is high while a packet is in flight. Requests and payload writes presented while busy are ignored.
- R10: In the cycle after the last beat is accepted, `tx_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pl_wr_en | input | 1 | Payload double-word write strobe (idle only) |
| pl_wr_idx | input | 5 | Double-word index into the payload store |
| pl_wr_data | input | 64 | Double-word, lowest-addressed byte in bits [63:56] |
| req_valid | input | 1 | Request strobe |
| req_len | input | 9 | Payload length in bytes |
| req_prio | input | 2 | Packet priority |
| req_dest | input | 8 | Destination device ID |
| req_src | input | 8 | Source device ID |
| req_addr | input | 29 | Double-word address |
| req_wdptr | input | 1 | Word pointer bit, carried through |
| req_xamsbs | input | 2 | Extended address MSBs |
| busy | output | 1 | Packet in flight |
| req_err | output | 1 | Rejected-request pulse |
| tx_ready | input | 1 | Downstream ready |
| tx_valid | output | 1 | Beat valid |
| tx_sop | output | 1 | First beat of packet |
| tx_eop | output | 1 | Last beat of packet |
| tx_empty | output | 4 | Unused bytes on the last beat |
| tx_size | output | 9 | Header plus payload length in bytes |
| tx_data | output | 128 | Beat data |

## Verification
The bench targets the one-beat packet (8-byte payload, start and end together), the odd-beat and maximal packets whose last beat is half empty, and the 40-byte case that fills three beats exactly. A design that counted beats from the payload alone would miss or add a beat, and one that padded wrongly would report an empty count of 0 with stale bytes in the low half. Irregular ready patterns check that a stalled beat is neither skipped nor changed. Requests and payload writes issued mid-packet must not corrupt the current frame or start a stray second one. Illegal lengths (0, 12, 264) must give a single error pulse and leave the bus quiet.

// File: rtl/swf_pkg.sv
package swf_pkg;
    localparam int          BUS_W        = 128;
    localparam int          DWORD_W      = 64;
    localparam int          HDR_BYTES    = 8;
    localparam logic [3:0]  FTYPE_STREAM = 4'b0110;
    localparam logic [1:0]  TT_ID8       = 2'b00;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FIRST = 2'd1,
        ST_BODY  = 2'd2
    } fr_state_e;

    typedef struct packed {
        logic [1:0]  prio;
        logic [7:0]  dest;
        logic [7:0]  src;
        logic [28:0] addr;
        logic        wdptr;
        logic [1:0]  xam;
    } swf_req_t;
endpackage

// File: rtl/swf_len_check.sv
module swf_len_check #(
    parameter int MAX_BYTES = 256,
    parameter int LEN_W     = 9,
    parameter int RD_W      = 6,
    parameter int BEAT_W    = 5,
    parameter int SIZE_W    = 9
) (
    input  logic [LEN_W-1:0]  len,
    output logic              ok,
    output logic [RD_W-1:0]   ndw,
    output logic [BEAT_W-1:0] last_beat,
    output logic [3:0]        empty,
    output logic [SIZE_W-1:0] size
);
    always_comb begin
        ndw       = RD_W'(len >> 3);
        ok        = (len != '0) && (len[2:0] == 3'b000) && (len <= LEN_W'(MAX_BYTES));
        last_beat = BEAT_W'(ndw >> 1);
        empty     = ndw[0] ? 4'd0 : 4'd8;
        size      = SIZE_W'(len) + SIZE_W'(swf_pkg::HDR_BYTES);
    end
endmodule

// File: rtl/swf_payload_buf.sv
module swf_payload_buf #(
    parameter int DEPTH  = 32,
    parameter int DATA_W = 64,
    parameter int IDX_W  = 5,
    parameter int RD_W   = 6
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [RD_W-1:0]   rd_hi_idx,
    input  logic [RD_W-1:0]   rd_lo_idx,
    output logic [DATA_W-1:0] rd_hi,
    output logic [DATA_W-1:0] rd_lo
);
    logic [DATA_W-1:0] slot [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [DATA_W-1:0] q;
        always_ff @(posedge clk) begin
            if (wr_en && (wr_idx == IDX_W'(i))) begin
                q <= wr_data;
            end
        end
        assign slot[i] = q;
    end

    always_comb begin
        rd_hi = (rd_hi_idx < RD_W'(DEPTH)) ? slot[rd_hi_idx[IDX_W-1:0]] : '0;
        rd_lo = (rd_lo_idx < RD_W'(DEPTH)) ? slot[rd_lo_idx[IDX_W-1:0]] : '0;
    end
endmodule

// File: rtl/swf_header_pack.sv
module swf_header_pack
    import swf_pkg::*;
(
    input  swf_req_t           req,
    output logic [DWORD_W-1:0] hdr
);
    // ackID, VC and CRF are zero; tt selects 8-bit IDs; ftype is streaming write
    assign hdr = {6'd0, 1'b0, 1'b0, req.prio, TT_ID8, FTYPE_STREAM,
                  req.dest, req.src, req.addr, req.wdptr, req.xam};
endmodule

// File: rtl/swrite_framer.sv
module swrite_framer
    import swf_pkg::*;
#(
    parameter int MAX_BYTES = 256
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         pl_wr_en,
    input  logic [4:0]   pl_wr_idx,
    input  logic [63:0]  pl_wr_data,
    input  logic         req_valid,
    input  logic [8:0]   req_len,
    input  logic [1:0]   req_prio,
    input  logic [7:0]   req_dest,
    input  logic [7:0]   req_src,
    input  logic [28:0]  req_addr,
    input  logic         req_wdptr,
    input  logic [1:0]   req_xamsbs,
    output logic         busy,
    output logic         req_err,
    input  logic         tx_ready,
    output logic         tx_valid,
    output logic         tx_sop,
    output logic         tx_eop,
    output logic [3:0]   tx_empty,
    output logic [8:0]   tx_size,
    output logic [127:0] tx_data
);
    localparam int DW_CNT = MAX_BYTES / 8;
    localparam int IDX_W  = $clog2(DW_CNT);
    localparam int RD_W   = IDX_W + 1;
    localparam int BEAT_W = $clog2(DW_CNT / 2 + 1);
    localparam int LEN_W  = $clog2(MAX_BYTES + 1);
    localparam int SIZE_W = $clog2(MAX_BYTES + HDR_BYTES + 1);

    fr_state_e          state_q, state_d;
    logic [DWORD_W-1:0] hdr_q;
    logic [BEAT_W-1:0]  beat_q, last_q;
    logic [RD_W-1:0]    ndw_q;
    logic [3:0]         empty_q;
    logic [SIZE_W-1:0]  size_q;
    logic               err_q;

    logic               len_ok;
    logic [RD_W-1:0]    len_ndw;
    logic [BEAT_W-1:0]  len_last;
    logic [3:0]         len_empty;
    logic [SIZE_W-1:0]  len_size;
    logic [DWORD_W-1:0] hdr_new;
    swf_req_t           req_fields;

    logic               idle, accept, reject, beat_go, at_last;
    logic [RD_W-1:0]    hi_idx, lo_idx;
    logic [DWORD_W-1:0] buf_hi, buf_lo;

    assign idle    = (state_q == ST_IDLE);
    assign accept  = idle && req_valid && len_ok;
    assign reject  = idle && req_valid && !len_ok;
    assign beat_go = !idle && tx_ready;
    assign at_last = (beat_q == last_q);

    assign req_fields = '{prio: req_prio, dest: req_dest, src: req_src,
                          addr: req_addr, wdptr: req_wdptr, xam: req_xamsbs};

    swf_len_check #(
        .MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W), .RD_W(RD_W),
        .BEAT_W(BEAT_W), .SIZE_W(SIZE_W)
    ) u_len (
        .len      (req_len),
        .ok       (len_ok),
        .ndw      (len_ndw),
        .last_beat(len_last),
        .empty    (len_empty),
        .size     (len_size)
    );

    swf_header_pack u_hdr (
        .req(req_fields),
        .hdr(hdr_new)
    );

    // beat k carries double-words 2k-1 (upper) and 2k (lower); beat 0 upper is the header
    assign hi_idx = (RD_W'(beat_q) << 1) - RD_W'(1);
    assign lo_idx =  RD_W'(beat_q) << 1;

    swf_payload_buf #(
        .DEPTH(DW_CNT), .DATA_W(DWORD_W), .IDX_W(IDX_W), .RD_W(RD_W)
    ) u_buf (
        .clk      (clk),
        .wr_en    (pl_wr_en && idle),
        .wr_idx   (IDX_W'(pl_wr_idx)),
        .wr_data  (pl_wr_data),
        .rd_hi_idx(hi_idx),
        .rd_lo_idx(lo_idx),
        .rd_hi    (buf_hi),
        .rd_lo    (buf_lo)
    );

    // next-state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = ST_FIRST;
            ST_FIRST: if (beat_go) state_d = at_last ? ST_IDLE : ST_BODY;
            ST_BODY:  if (beat_go && at_last) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // request capture and beat counter
    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q  <= '0;
            last_q  <= '0;
            ndw_q   <= '0;
            empty_q <= '0;
            size_q  <= '0;
            hdr_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            err_q <= reject;
            if (accept) begin
                beat_q  <= '0;
                last_q  <= len_last;
                ndw_q   <= len_ndw;
                empty_q <= len_empty;
                size_q  <= len_size;
                hdr_q   <= hdr_new;
            end else if (beat_go && !at_last) begin
                beat_q <= beat_q + BEAT_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        busy     = !idle;
        req_err  = err_q;
        tx_valid = !idle;
        tx_sop   = (state_q == ST_FIRST);
        tx_eop   = !idle && at_last;
        tx_empty = (!idle && at_last) ? empty_q : 4'd0;
        tx_size  = idle ? '0 : 9'(size_q);
        tx_data  = '0;
        if (!idle) begin
            tx_data[127:64] = (state_q == ST_FIRST) ? hdr_q : buf_hi;
            tx_data[63:0]   = (lo_idx < ndw_q) ? buf_lo : '0;
        end
    end

    a_r7_hold_when_stalled: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_sop)
                                     && $stable(tx_eop) && $stable(tx_size) && $stable(tx_empty)));

    a_r10_drop_after_last: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready && tx_eop) |=> !tx_valid);

    a_r4_sop_only_first: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready && !tx_eop) |=> (tx_valid && !tx_sop));

    a_r8_err_quiet_bus: assert property (@(posedge clk) disable iff (rst)
        req_err |-> (!tx_valid && !busy));

    a_r6_empty_only_last: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_eop) |-> (tx_empty == 4'd0));

    a_r6_empty_legal: assert property (@(posedge clk) disable iff (rst)
        tx_eop |-> (tx_empty == 4'd0 || tx_empty == 4'd8));

    a_r9_busy_holds_size: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !$past(tx_valid && tx_ready && tx_eop)) |-> $stable(tx_size));
endmodule

// File: tb/tb_swrite_framer.sv
module tb_swrite_framer;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         pl_wr_en = 1'b0;
    logic [4:0]   pl_wr_idx = '0;
    logic [63:0]  pl_wr_data = '0;
    logic         req_valid = 1'b0;
    logic [8:0]   req_len = '0;
    logic [1:0]   req_prio = '0;
    logic [7:0]   req_dest = '0;
    logic [7:0]   req_src = '0;
    logic [28:0]  req_addr = '0;
    logic         req_wdptr = 1'b0;
    logic [1:0]   req_xamsbs = '0;
    logic         busy, req_err, tx_valid, tx_sop, tx_eop;
    logic         tx_ready = 1'b0;
    logic [3:0]   tx_empty;
    logic [8:0]   tx_size;
    logic [127:0] tx_data;

    int checks = 0;
    int failures = 0;
    logic [63:0] mem [32];

    always #(CLK_PERIOD/2) clk = ~clk;

    swrite_framer dut (
        .clk(clk), .rst(rst),
        .pl_wr_en(pl_wr_en), .pl_wr_idx(pl_wr_idx), .pl_wr_data(pl_wr_data),
        .req_valid(req_valid), .req_len(req_len), .req_prio(req_prio),
        .req_dest(req_dest), .req_src(req_src), .req_addr(req_addr),
        .req_wdptr(req_wdptr), .req_xamsbs(req_xamsbs),
        .busy(busy), .req_err(req_err),
        .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_sop(tx_sop), .tx_eop(tx_eop),
        .tx_empty(tx_empty), .tx_size(tx_size), .tx_data(tx_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] mk_hdr(input logic [1:0] p, input logic [7:0] d, input logic [7:0] s,
                                           input logic [28:0] a, input logic w, input logic [1:0] x);
        return {6'd0, 1'b0, 1'b0, p, 2'b00, 4'b0110, d, s, a, w, x};
    endfunction

    function automatic logic [127:0] exp_beat(input int k, input int len, input logic [63:0] hdr);
        logic [63:0] hi, lo;
        hi = (k == 0) ? hdr : mem[2*k-1];
        lo = (2*k < len/8) ? mem[2*k] : 64'd0;
        return {hi, lo};
    endfunction

    task automatic load_payload(input int n_dw, input int seed);
        for (int i = 0; i < n_dw; i++) begin
            @(negedge clk);
            pl_wr_en   = 1'b1;
            pl_wr_idx  = 5'(i);
            pl_wr_data = {32'(seed * 7919 + i), 8'(i), 24'hC0DE00 ^ 24'(seed)};
            mem[i]     = pl_wr_data;
        end
        @(negedge clk);
        pl_wr_en = 1'b0;
    endtask

    task automatic issue_req(input int len, input logic [1:0] p, input logic [7:0] d, input logic [7:0] s,
                             input logic [28:0] a, input logic w, input logic [1:0] x);
        @(negedge clk);
        req_valid = 1'b1; req_len = 9'(len); req_prio = p; req_dest = d;
        req_src = s; req_addr = a; req_wdptr = w; req_xamsbs = x;
    endtask

    function automatic bit rdy_of(input int mode, input int cyc);
        case (mode)
            1:       return (cyc % 2) == 1;
            2:       return (cyc % 3) == 2;
            default: return 1'b1;
        endcase
    endfunction

    // collects one packet, checking every presented beat (stalled ones included)
    task automatic run_packet(input int len, input int rmode, input logic [63:0] hdr, input bit poke);
        int  k = 0;
        int  cyc = 0;
        int  last = (len/8)/2;
        bit  done = 0;
        bit  rdy;
        while (!done && cyc < 2000) begin
            @(negedge clk);
            req_valid = 1'b0;
            pl_wr_en  = 1'b0;
            if (poke && cyc == 1) begin
                req_valid = 1'b1; req_len = 9'd8; req_dest = 8'h11;
                pl_wr_en = 1'b1; pl_wr_idx = 5'd3; pl_wr_data = 64'hDEAD_BEEF_DEAD_BEEF;
            end
            rdy = rdy_of(rmode, cyc);
            tx_ready = rdy;
            cyc++;
            chk(tx_valid === 1'b1, "R4 valid during packet", 128'(tx_valid), 128'd1);
            chk(busy === 1'b1, "R9 busy in flight", 128'(busy), 128'd1);
            chk(req_err === 1'b0, "R9 no error while busy", 128'(req_err), 128'd0);
            if (tx_valid !== 1'b1) begin
                done = 1;
            end else begin
                if (k == 0)
                    chk(tx_data[127:64] === hdr, "R2 header", 128'(tx_data[127:64]), 128'(hdr));
                chk(tx_data === exp_beat(k, len, hdr), rdy ? "R5 beat data" : "R7 stalled data",
                    tx_data, exp_beat(k, len, hdr));
                chk(tx_sop === (k == 0), "R4 sop", 128'(tx_sop), 128'(k == 0));
                chk(tx_eop === (k == last), "R4 eop", 128'(tx_eop), 128'(k == last));
                chk(tx_size === 9'(len + 8), "R3 size", 128'(tx_size), 128'(len + 8));
                chk(tx_empty === ((k == last && ((len/8) % 2 == 0)) ? 4'd8 : 4'd0), "R6 empty",
                    128'(tx_empty), 128'((k == last && ((len/8) % 2 == 0)) ? 8 : 0));
                if (rdy) begin
                    if (k == last) done = 1;
                    k++;
                end
            end
        end
        chk(k == last + 1, "R4 beat count", 128'(k), 128'(last + 1));
        @(negedge clk);
        req_valid = 1'b0;
        pl_wr_en  = 1'b0;
        tx_ready  = 1'b1;
        chk(tx_valid === 1'b0, "R10 valid low after last", 128'(tx_valid), 128'd0);
        chk(busy === 1'b0, "R9 idle after last", 128'(busy), 128'd0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(tx_valid === 1'b0 && busy === 1'b0 && req_err === 1'b0, "R1 reset state",
            128'({tx_valid, busy, req_err}), 128'd0);
        rst = 1'b0;
    endtask

    task automatic t_reset_mid();
        load_payload(6, 9);
        issue_req(40, 2'd1, 8'h22, 8'h33, 29'h44, 1'b0, 2'd1);
        @(negedge clk);
        req_valid = 1'b0; tx_ready = 1'b0;
        chk(tx_valid === 1'b1, "R1 packet started", 128'(tx_valid), 128'd1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(tx_valid === 1'b0 && busy === 1'b0 && req_err === 1'b0, "R1 mid-packet reset",
            128'({tx_valid, busy, req_err}), 128'd0);
    endtask

    task automatic t_example();
        logic [63:0] h;
        h = mk_hdr(2'b11, 8'hDD, 8'hAA, {28'h0AABBCC, 1'b1}, 1'b1, 2'b00);
        load_payload(5, 1);
        issue_req(40, 2'b11, 8'hDD, 8'hAA, {28'h0AABBCC, 1'b1}, 1'b1, 2'b00);
        run_packet(40, 0, h, 1'b0);
    endtask

    task automatic t_single();
        logic [63:0] h;
        h = mk_hdr(2'b01, 8'h5A, 8'hA5, 29'h1FFF_FFFF, 1'b0, 2'b11);
        load_payload(1, 2);
        issue_req(8, 2'b01, 8'h5A, 8'hA5, 29'h1FFF_FFFF, 1'b0, 2'b11);
        run_packet(8, 2, h, 1'b0);
    endtask

    task automatic t_half_last();
        logic [63:0] h;
        h = mk_hdr(2'b10, 8'h01, 8'hFE, 29'h0123_4567, 1'b1, 2'b10);
        load_payload(2, 3);
        issue_req(16, 2'b10, 8'h01, 8'hFE, 29'h0123_4567, 1'b1, 2'b10);
        run_packet(16, 1, h, 1'b0);
    endtask

    task automatic t_max();
        logic [63:0] h;
        h = mk_hdr(2'b00, 8'h80, 8'h7F, 29'h1555_5555, 1'b0, 2'b01);
        load_payload(32, 4);
        issue_req(256, 2'b00, 8'h80, 8'h7F, 29'h1555_5555, 1'b0, 2'b01);
        run_packet(256, 2, h, 1'b0);
    endtask

    task automatic t_bad(input int len);
        issue_req(len, 2'b11, 8'h99, 8'h88, 29'h7, 1'b0, 2'b00);
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_err === 1'b1, "R8 error pulse", 128'(req_err), 128'd1);
        chk(tx_valid === 1'b0 && busy === 1'b0, "R8 no transmit", 128'({tx_valid, busy}), 128'd0);
        @(negedge clk);
        chk(req_err === 1'b0, "R8 pulse one cycle", 128'(req_err), 128'd0);
        chk(tx_valid === 1'b0, "R8 still quiet", 128'(tx_valid), 128'd0);
    endtask

    task automatic t_busy_ignore();
        logic [63:0] h;
        h = mk_hdr(2'b10, 8'h3C, 8'hC3, 29'h0ABC_DEF0, 1'b0, 2'b00);
        load_payload(5, 5);
        issue_req(40, 2'b10, 8'h3C, 8'hC3, 29'h0ABC_DEF0, 1'b0, 2'b00);
        run_packet(40, 1, h, 1'b1);
        repeat (3) begin
            @(negedge clk);
            chk(tx_valid === 1'b0, "R9 no queued packet", 128'(tx_valid), 128'd0);
        end
        // resend without rewriting: index 3 must still hold the value written while idle
        issue_req(40, 2'b10, 8'h3C, 8'hC3, 29'h0ABC_DEF0, 1'b0, 2'b00);
        run_packet(40, 0, h, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_example();
        t_single();
        t_half_last();
        t_max();
        t_bad(0);
        t_bad(12);
        t_bad(264);
        t_busy_ignore();
        t_reset_mid();
        t_example();
        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule